// File: doc/BRIEF.md
# Dual-Word DDS Waveform Generator Core

This core is a direct digital synthesis engine that runs on a master clock. It holds two 28-bit tuning words. A select input picks one of them, and on every master clock edge the chosen word is added, modulo 2^28, to a 28-bit phase accumulator. The output frequency is the master clock frequency times the tuning word divided by 2^28. With a 16 MHz clock one tuning LSB is about 0.06 Hz. A word of 0x2492492 gives one seventh of the clock rate.

The top 12 phase bits are turned into a 10-bit sample. The sample can be one of three shapes: a sine taken from a table built at elaboration time, a triangle made by folding the phase, or a square wave taken from the phase MSB. The sample is registered, so it reflects the phase one cycle earlier. A separate 1-bit clock output always carries the registered phase MSB, so a square clock stays available when the sample path is muted.

Two independent sleep inputs are provided. One freezes the accumulator. The other blanks the sample word. A host loads the tuning words through simple write-enable ports and changes frequency, shape and sleep state through level inputs.

Top module: `dds_wavegen_core`

## Requirements
- R1: While `rst_n` is low, `sample_o`, `clk_o`, the phase and both tuning words are 0. With both words left at 0 after reset, the phase stays 0.
- R2: On every clock edge where `halt_accum` is 0, the phase becomes (phase + selected tuning word) mod 2^28. The wrap past 2^28 is seamless.
- R3: When `tw_wr_en[i]` is 1 at an edge, tuning word i takes `tw_wr_data` at that edge. The new value first steps the phase at the following edge. A write in the same edge that selects the word therefore steps with the old value.
- R4: `tw_sel` (0 = word 0, 1 = word 1) picks the step used at each edge. Changing it does not reset or disturb the phase.
- R5: When `wave_sel` = 00 (sine), let p = phase[27:16] and a = floor(511.5·|sin(2π(p+0.5)/4096)| + 0.5). The sample is then 512+a for p < 2048 and 511−a otherwise, in offset binary.
- R6: When `wave_sel` = 01 (triangle), let t = phase[27:17]. The sample is t[9:0] if t[10] is 0 and ~t[9:0] if t[10] is 1.
- R7: When `wave_sel` = 10 (square), the sample is all ones when phase[27] is 1 and all zeros otherwise.
- R8: The sample and `clk_o` seen after edge k are computed from the phase held before edge k. This is a fixed one-cycle latency.
- R9: While `halt_accum` is 1 at an edge, the phase keeps its value.
- R10: While `mute_out` is 1 at an edge, `sample_o` becomes 0 after that edge. The phase and `clk_o` are not affected.
- R11: `clk_o` is the registered phase[27] in every shape and mute state.
- R12: `wave_sel` = 11 behaves exactly like square (10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tw_wr_en | input | 2 | Per-word write enable; bit i loads word i |
| tw_wr_data | input | 28 | Tuning word value to load |
| tw_sel | input | 1 | Selects the tuning word that steps the phase |
| wave_sel | input | 2 | Shape: 00 sine, 01 triangle, 10/11 square |
| halt_accum | input | 1 | Freezes the phase accumulator |
| mute_out | input | 1 | Forces the sample word to 0 |
| sample_o | output | 10 | Registered sample, offset binary |
| clk_o | output | 1 | Registered phase MSB (square clock) |

## Verification
The word select and a tuning-word write can hit the same edge. The bench provokes this by raising `tw_sel` and the enable of word 1 together, with a new value, in a single cycle. The step at that edge must use the old stored word, and the new word must take over one edge later; the triangle output shows this. Muting and halting are also overlapped with a running accumulator. The bench judges each cycle against a cycle model written from the requirements, comparing both `sample_o` and `clk_o`.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        WAVE_SINE    = 2'b00,
        WAVE_TRI     = 2'b01,
        WAVE_SQR     = 2'b10,
        WAVE_SQR_ALT = 2'b11
    } wave_e;

    // Amplitude of the quarter-wave sine at index k, half-step centred,
    // rounded half-up, for a lut_w-bit phase and an out_w-bit sample.
    function automatic int quarter_sine_amp(input int k, input int lut_w, input int out_w);
        real full;
        real half;
        real ang;
        full = real'(64'(1) << lut_w);
        half = real'(64'(1) << (out_w - 1)) - 0.5;
        ang  = 6.283185307179586 * (real'(k) + 0.5) / full;
        return $rtoi(half * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/dds_tuning_regs.sv
module dds_tuning_regs #(
    parameter int ACC_W     = 28,
    parameter int NUM_WORDS = 2,
    localparam int SEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WORDS-1:0] wr_en,
    input  logic [ACC_W-1:0]     wr_data,
    input  logic [SEL_W-1:0]     sel,
    output logic [ACC_W-1:0]     step_o
);

    typedef struct packed {
        logic [NUM_WORDS-1:0][ACC_W-1:0] word;
    } tw_state_t;

    tw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (wr_en[i]) begin
                st_d.word[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The stored word, not the write bus, steps the phase
    assign step_o = st_q.word[sel];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_load_chk
        // R3
        tw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[g] |=> (st_q.word[g] == $past(wr_data)));
    end

endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
    parameter int ACC_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase_o
);

    typedef struct packed {
        logic [ACC_W-1:0] phase;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!halt) begin
            // natural modulo-2^ACC_W wrap
            st_d.phase = st_q.phase + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(phase_o));

endmodule

// File: rtl/dds_wave_shaper.sv
module dds_wave_shaper #(
    parameter int LUT_W = 12,
    parameter int OUT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LUT_W-1:0]  phase_top,
    input  dds_pkg::wave_e    wave,
    input  logic              mute,
    output logic [OUT_W-1:0]  sample_o,
    output logic              clk_o
);

    localparam int Q_W   = LUT_W - 2;
    localparam int QTR   = 1 << Q_W;
    localparam int AMP_W = OUT_W - 1;
    localparam int TRI_W = OUT_W + 1;

    typedef struct packed {
        logic [OUT_W-1:0] sample;
        logic             clkbit;
    } shp_state_t;

    shp_state_t st_d, st_q;

    // Quarter-wave table filled at elaboration
    logic [AMP_W-1:0] qrom [QTR];
    for (genvar k = 0; k < QTR; k++) begin : g_qrom
        assign qrom[k] = AMP_W'(dds_pkg::quarter_sine_amp(k, LUT_W, OUT_W));
    end

    logic [Q_W-1:0]   qidx;
    logic [AMP_W-1:0] amp;
    logic [OUT_W-1:0] sine_val;
    logic [TRI_W-1:0] tri_top;
    logic [OUT_W-1:0] tri_val;
    logic [OUT_W-1:0] sqr_val;

    always_comb begin
        // mirror the second and fourth quarters
        qidx     = phase_top[LUT_W-2] ? ~phase_top[Q_W-1:0] : phase_top[Q_W-1:0];
        amp      = qrom[qidx];
        sine_val = phase_top[LUT_W-1] ? {1'b0, ~amp} : {1'b1, amp};

        tri_top  = phase_top[LUT_W-1 -: TRI_W];
        tri_val  = tri_top[TRI_W-1] ? ~tri_top[OUT_W-1:0] : tri_top[OUT_W-1:0];

        sqr_val  = {OUT_W{phase_top[LUT_W-1]}};
    end

    always_comb begin
        st_d        = st_q;
        st_d.clkbit = phase_top[LUT_W-1];
        unique case (wave)
            dds_pkg::WAVE_SINE: st_d.sample = sine_val;
            dds_pkg::WAVE_TRI:  st_d.sample = tri_val;
            default:            st_d.sample = sqr_val;
        endcase
        if (mute) begin
            st_d.sample = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o = st_q.sample;
    assign clk_o    = st_q.clkbit;

    // R10
    mute_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> (sample_o == '0));

    // R7
    square_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute && (wave == dds_pkg::WAVE_SQR || wave == dds_pkg::WAVE_SQR_ALT))
        |=> (sample_o == {OUT_W{clk_o}}));

endmodule

// File: rtl/dds_wavegen_core.sv
module dds_wavegen_core #(
    parameter int ACC_W     = 28,
    parameter int LUT_W     = 12,
    parameter int OUT_W     = 10,
    parameter int NUM_WORDS = 2,
    localparam int SEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WORDS-1:0] tw_wr_en,
    input  logic [ACC_W-1:0]     tw_wr_data,
    input  logic [SEL_W-1:0]     tw_sel,
    input  logic [1:0]           wave_sel,
    input  logic                 halt_accum,
    input  logic                 mute_out,
    output logic [OUT_W-1:0]     sample_o,
    output logic                 clk_o
);

    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] phase;
    logic [LUT_W-1:0] phase_top;
    dds_pkg::wave_e   wave;

    assign wave      = dds_pkg::wave_e'(wave_sel);
    assign phase_top = phase[ACC_W-1 -: LUT_W];

    dds_tuning_regs #(
        .ACC_W     (ACC_W),
        .NUM_WORDS (NUM_WORDS)
    ) tuning_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tw_wr_en),
        .wr_data (tw_wr_data),
        .sel     (tw_sel),
        .step_o  (step)
    );

    dds_phase_accum #(
        .ACC_W (ACC_W)
    ) accum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (halt_accum),
        .step    (step),
        .phase_o (phase)
    );

    dds_wave_shaper #(
        .LUT_W (LUT_W),
        .OUT_W (OUT_W)
    ) shaper_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_top (phase_top),
        .wave      (wave),
        .mute      (mute_out),
        .sample_o  (sample_o),
        .clk_o     (clk_o)
    );

    // R11
    clk_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (clk_o == $past(phase[ACC_W-1])));

endmodule

// File: tb/dds_wavegen_core_tb.sv
module dds_wavegen_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tw_wr_en = '0;
    logic [27:0] tw_wr_data = '0;
    logic        tw_sel = 1'b0;
    logic [1:0]  wave_sel = 2'b00;
    logic        halt_accum = 1'b0;
    logic        mute_out = 1'b0;
    logic [9:0]  sample_o;
    logic        clk_o;

    int n_checks = 0;
    int n_fail   = 0;
    int n_cycles = 0;

    // cycle model state
    logic [27:0] m_phase;
    logic [27:0] m_tw [2];
    logic [9:0]  m_sample;
    logic        m_clk;

    always #4 clk = ~clk;

    dds_wavegen_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tw_wr_en   (tw_wr_en),
        .tw_wr_data (tw_wr_data),
        .tw_sel     (tw_sel),
        .wave_sel   (wave_sel),
        .halt_accum (halt_accum),
        .mute_out   (mute_out),
        .sample_o   (sample_o),
        .clk_o      (clk_o)
    );

    function automatic logic [9:0] ref_shape(logic [27:0] ph, logic [1:0] w);
        logic [11:0] p;
        logic [10:0] t;
        real s;
        int a;
        p = ph[27:16];
        t = ph[27:17];
        case (w)
            2'b00: begin
                s = $sin(6.283185307179586 * (real'(p) + 0.5) / 4096.0);
                if (s < 0.0) s = -s;
                a = $rtoi($floor(511.5 * s + 0.5));
                return p[11] ? 10'(511 - a) : 10'(512 + a);
            end
            2'b01:   return t[10] ? ~t[9:0] : t[9:0];
            default: return {10{ph[27]}};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        n_cycles++;
        m_sample = mute_out ? 10'd0 : ref_shape(m_phase, wave_sel);
        m_clk    = m_phase[27];
        if (!halt_accum) m_phase = m_phase + m_tw[tw_sel];
        for (int i = 0; i < 2; i++) if (tw_wr_en[i]) m_tw[i] = tw_wr_data;
        @(negedge clk);
        check(sample_o == m_sample, {req, " sample"}, int'(sample_o), int'(m_sample));
        check(clk_o == m_clk, {req, " clk_o"}, int'(clk_o), int'(m_clk));
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) tick(req);
    endtask

    task automatic write_word(input int idx, input logic [27:0] val, input string req);
        tw_wr_en[idx] = 1'b1;
        tw_wr_data    = val;
        tick(req);
        tw_wr_en      = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tw_wr_en = '0; tw_sel = 1'b0; halt_accum = 1'b0; mute_out = 1'b0;
        m_phase = '0; m_tw[0] = '0; m_tw[1] = '0; m_sample = '0; m_clk = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sample_o == 10'd0, "R1 sample in reset", int'(sample_o), 0);
        check(clk_o == 1'b0, "R1 clk_o in reset", int'(clk_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        wave_sel = 2'b11;
        do_reset();
        wave_sel = 2'b01;
        run(6, "R1");
    endtask

    task automatic t_triangle();
        do_reset();
        wave_sel = 2'b01;
        write_word(0, 28'((3 << 17) + 12345), "R3");
        run(720, "R2 R6 R8");
    endtask

    task automatic t_sine();
        do_reset();
        wave_sel = 2'b00;
        write_word(0, 28'((37 << 16) + 999), "R3");
        run(300, "R5 R8");
    endtask

    task automatic t_square();
        do_reset();
        wave_sel = 2'b10;
        write_word(0, 28'h2492492, "R3");
        run(60, "R7 R11");
        wave_sel = 2'b11;
        run(30, "R12");
    endtask

    task automatic t_select();
        do_reset();
        wave_sel = 2'b01;
        write_word(1, 28'(5 << 17), "R3");
        write_word(0, 28'(1 << 17), "R3");
        for (int k = 0; k < 12; k++) begin
            tw_sel = k[0];
            run(7, "R4");
        end
        // select and write of the same word in one edge
        tw_sel = 1'b0;
        tick("R4");
        tw_sel        = 1'b1;
        tw_wr_en[1]   = 1'b1;
        tw_wr_data    = 28'(9 << 17);
        tick("R3 R4 coincident");
        tw_wr_en      = '0;
        run(12, "R3 R4 after coincident");
    endtask

    task automatic t_halt();
        do_reset();
        wave_sel = 2'b01;
        write_word(0, 28'(2 << 17), "R3");
        run(15, "R2");
        halt_accum = 1'b1;
        run(20, "R9");
        halt_accum = 1'b0;
        run(10, "R9 release");
    endtask

    task automatic t_mute();
        do_reset();
        wave_sel = 2'b00;
        write_word(0, 28'h2492492, "R3");
        run(10, "R5");
        mute_out = 1'b1;
        run(30, "R10 R11");
        halt_accum = 1'b1;
        run(5, "R9 R10");
        halt_accum = 1'b0;
        mute_out = 1'b0;
        run(10, "R10 release");
    endtask

    initial begin
        t_reset();
        t_triangle();
        t_sine();
        t_square();
        t_select();
        t_halt();
        t_mute();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", n_cycles, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule